// File: doc/BRIEF.md
# Buffered BCD Calendar Counter

This block keeps wall-clock time as eight packed-BCD fields: second, minute, hour, weekday, day of month, month, year and century. A host reaches the fields through a byte-wide register port. Reads are combinational from a separate read address. Writes take effect at the next clock edge. The count moves forward by one second on each cycle in which the one-pulse-per-second input `tickEn` is high. A stop bit in the month register blocks this.

The host never writes the running counters directly. It sees a shadow copy. While the transfer bit in the control register is set, the shadow copy follows the counters on every clock. The host sets a new time in three steps:

1. Clear the transfer bit. This freezes the shadow copy.
2. Write any subset of the fields.
3. Set the transfer bit again.

On step 3 the written fields replace the running ones in a single cycle. The fields the host did not touch keep their own running count, and that count may include a tick in the same cycle.

Top module: `cal_clock`

## Requirements
- R1: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the date. Every field is held as packed BCD, with the tens digit in the upper nibble.
- R2: The read layout is as follows. Any unused bit reads 0, and any other address reads 0x00.
  - 0x00: seconds in bits 6:0.
  - 0x01: minutes in bits 6:0.
  - 0x02: hours in bits 5:0.
  - 0x03: weekday in bits 2:0.
  - 0x04: date in bits 5:0.
  - 0x05: month in bits 4:0, the stop bit in bit 7, and two spare control bits in bits 6:5.
  - 0x06: year in bits 7:0.
  - 0x07: century in bits 5:0.
  - 0x0F: the transfer bit in bit 7.
  
  Bits written outside a field are dropped. Writes to unmapped addresses change nothing.
- R3: While the transfer bit is 0, the shadow registers stop following the counters. A host write changes only the shadow copy, and the counters keep counting.
- R4: While the transfer bit is 1, the shadow copy equals the counters after every clock edge. Writes to the time fields at 0x00–0x07 are ignored. The month control bits are still written.
- R5: A write of 1 to bit 7 of 0x0F while the transfer bit is 0 is a commit. In that cycle, every field written since the bit fell takes the host value. Every other field takes its normal next count.
- R6: The count advances only when `tickEn` is 1 and the stop bit (0x05 bit 7) is 0. When the stop bit is 1, ticks are ignored.
- R7: The date rolls to 01 after its month's last day. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For month 02 it is 28, or 29 when the BCD year is a multiple of four (00 counts as a multiple).
- R8: Year rolls from 99 to 00 and increments the century. The century rolls from `CENTURY_LAST` (default BCD 39) to 00.
- R9: The weekday advances at each date rollover and wraps from 7 to 1.
- R10: After reset, the time reads 00:00:00 on weekday 1, date 01, month 01, year 00, century 00. The transfer bit is 1 and the three month control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-second advance enable, one cycle wide |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | 8 | Host write data |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | 8 | Read data for `rdAddr`, combinational |

## Verification
The bench builds the block with its defaults: a 5-bit address and a century limit of BCD 39. With these values, a few host writes followed by a few ticks can reach every rollover, including the century wrap at 39 and the leap-year cases for years 00, 12, 23 and 24. Because `tickEn` may pulse on every clock, a whole day boundary or a commit that coincides with a tick needs only a handful of cycles. The read address sweeps all 32 locations, so the unmapped and masked bits are checked on every pass.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FIELD_CNT = 8;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(FIELD_CNT);

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  typedef struct packed {
    logic [FIELD_CNT-1:0] visWe;
    logic [FIELD_CNT-1:0] takeMask;
    logic                 commit;
    logic                 follow;
    logic                 advance;
    logic [BYTE_W-1:0]    data;
  } strobe_t;

  function automatic logic [BYTE_W-1:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_DOW:          return 8'h07;
      F_MON:          return 8'h1F;
      F_YEAR:         return 8'hFF;
      default:        return 8'h3F;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] resetValue(input int idx);
    return (idx == F_DOW || idx == F_DATE || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [BYTE_W-1:0] stepField(input logic [BYTE_W-1:0] v,
                                                  input logic [BYTE_W-1:0] last,
                                                  input logic [BYTE_W-1:0] first);
    return (v >= last) ? first : bcdInc(v);
  endfunction

  function automatic logic leapYear(input logic [BYTE_W-1:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [BYTE_W-1:0] monthLast(input logic [BYTE_W-1:0] mon,
                                                  input logic [BYTE_W-1:0] yr);
    case (mon)
      8'h02:                      return leapYear(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [BYTE_W-1:0]    wrData,
  output strobe_t              stb,
  output logic                 teOut,
  output logic [2:0]           monCtl
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8'h0F);
  localparam logic [ADDR_W-1:0] MON_ADDR  = ADDR_W'(F_MON);

  logic                 teQ;
  logic [FIELD_CNT-1:0] dirtyQ;
  logic [2:0]           monCtlQ;
  logic                 wrTime;
  logic                 wrCtrl;

  assign wrTime = wrEn && (wrAddr < ADDR_W'(FIELD_CNT));
  assign wrCtrl = wrEn && (wrAddr == CTRL_ADDR);

  always_comb begin
    stb = '0;
    if (wrTime && !teQ) stb.visWe[wrAddr[IDX_W-1:0]] = 1'b1;
    stb.commit   = wrCtrl && wrData[7] && !teQ;
    stb.takeMask = dirtyQ;
    stb.follow   = teQ || stb.commit;
    stb.advance  = tickEn && !monCtlQ[2];
    stb.data     = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      teQ     <= 1'b1;
      dirtyQ  <= '0;
      monCtlQ <= '0;
    end else begin
      if (wrCtrl) teQ <= wrData[7];
      if (stb.commit) dirtyQ <= '0;
      else            dirtyQ <= dirtyQ | stb.visWe;
      if (wrEn && wrAddr == MON_ADDR) monCtlQ <= wrData[7:5];
    end
  end

  assign teOut  = teQ;
  assign monCtl = monCtlQ;

  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && wrData[7] && !teQ) |=> (teQ && dirtyQ == '0));

  assert_time_writes_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (teQ && !(wrCtrl && !wrData[7])) |=> (dirtyQ == '0));
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter logic [7:0] CENTURY_LAST = 8'h39
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             stb,
  output logic [FIELD_CNT-1:0][BYTE_W-1:0]    visOut
);
  logic [FIELD_CNT-1:0][BYTE_W-1:0] cnt;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] visReg;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] nxt;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] merged;
  logic carrySec, carryMin, carryHour, carryDate, carryMon, carryYear;
  logic [BYTE_W-1:0] lastDate;

  assign lastDate  = monthLast(cnt[F_MON], cnt[F_YEAR]);
  assign carrySec  = stb.advance && (cnt[F_SEC]  >= 8'h59);
  assign carryMin  = carrySec    && (cnt[F_MIN]  >= 8'h59);
  assign carryHour = carryMin    && (cnt[F_HOUR] >= 8'h23);
  assign carryDate = carryHour   && (cnt[F_DATE] >= lastDate);
  assign carryMon  = carryDate   && (cnt[F_MON]  >= 8'h12);
  assign carryYear = carryMon    && (cnt[F_YEAR] >= 8'h99);

  always_comb begin
    nxt = cnt;
    if (stb.advance) nxt[F_SEC] = stepField(cnt[F_SEC], 8'h59, 8'h00);
    if (carrySec)    nxt[F_MIN] = stepField(cnt[F_MIN], 8'h59, 8'h00);
    if (carryMin)    nxt[F_HOUR] = stepField(cnt[F_HOUR], 8'h23, 8'h00);
    if (carryHour) begin
      nxt[F_DOW]  = stepField(cnt[F_DOW], 8'h07, 8'h01);
      nxt[F_DATE] = stepField(cnt[F_DATE], lastDate, 8'h01);
    end
    if (carryDate)   nxt[F_MON]  = stepField(cnt[F_MON], 8'h12, 8'h01);
    if (carryMon)    nxt[F_YEAR] = stepField(cnt[F_YEAR], 8'h99, 8'h00);
    if (carryYear)   nxt[F_CENT] = stepField(cnt[F_CENT], CENTURY_LAST, 8'h00);
  end

  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_merge
    assign merged[f] = (stb.commit && stb.takeMask[f]) ? visReg[f] : nxt[f];

    assert_frozen_field_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.follow && !stb.visWe[f]) |=> $stable(visReg[f]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < FIELD_CNT; f++) begin
        cnt[f]    <= resetValue(f);
        visReg[f] <= resetValue(f);
      end
    end else begin
      for (int f = 0; f < FIELD_CNT; f++) begin
        cnt[f] <= merged[f];
        if (stb.visWe[f])    visReg[f] <= stb.data & fieldMask(f);
        else if (stb.follow) visReg[f] <= merged[f];
      end
    end
  end

  assign visOut = visReg;

  assert_shadow_tracks_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.follow |=> (visReg == cnt));

  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.commit) |=> $stable(cnt));

  assert_sec_moves_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.commit && cnt[F_SEC] < 8'h59) |=> (cnt[F_SEC] != $past(cnt[F_SEC])));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int         ADDR_W       = 5,
  parameter logic [7:0] CENTURY_LAST = 8'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8'h0F);
  localparam logic [ADDR_W-1:0] MON_ADDR  = ADDR_W'(F_MON);

  strobe_t                          stb;
  logic                             teBit;
  logic [2:0]                       monCtl;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] visOut;

  cal_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb),
    .teOut  (teBit),
    .monCtl (monCtl)
  );

  cal_datapath #(.CENTURY_LAST(CENTURY_LAST)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .visOut (visOut)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr < ADDR_W'(FIELD_CNT)) rdData = visOut[rdAddr[IDX_W-1:0]];
    if (rdAddr == MON_ADDR)  rdData[7:5] = monCtl;
    if (rdAddr == CTRL_ADDR) rdData = {teBit, 7'b0};
  end
endmodule

// File: tb/test_cal_clock.sv
`timescale 1ns/1ps
module test_cal_clock;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [4:0] rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string curReq = "R10";

  int  mCnt[8];
  int  mVis[8];
  bit  mDirty[8];
  bit  mTe, mStop, mE32, mBb;

  cal_clock i_cal_clock (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int toBcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int fromBcd(input int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  function automatic int maskOf(input int a);
    case (a)
      0, 1: return 'h7F;
      2, 4: return 'h3F;
      3: return 'h07;
      5: return 'h1F;
      6: return 'hFF;
      default: return 'h3F;
    endcase
  endfunction

  function automatic int daysIn(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int expRead(input int a);
    if (a < 8) begin
      int v = toBcd(mVis[a]);
      if (a == 5) v = v | (int'(mStop) << 7) | (int'(mE32) << 6) | (int'(mBb) << 5);
      return v;
    end
    if (a == 15) return int'(mTe) << 7;
    return 0;
  endfunction

  task automatic modelReset();
    mCnt = '{0, 0, 0, 1, 1, 1, 0, 0};
    mVis = mCnt;
    foreach (mDirty[i]) mDirty[i] = 0;
    mTe = 1; mStop = 0; mE32 = 0; mBb = 0;
  endtask

  task automatic modelClock(input bit tk, input bit w, input int a, input int d);
    int nx[8];
    bit adv, commit, follow;
    nx = mCnt;
    adv = tk && !mStop;
    commit = 0;
    if (adv) begin
      nx[0]++;
      if (nx[0] > 59) begin
        nx[0] = 0; nx[1]++;
        if (nx[1] > 59) begin
          nx[1] = 0; nx[2]++;
          if (nx[2] > 23) begin
            nx[2] = 0;
            nx[3] = (nx[3] >= 7) ? 1 : nx[3] + 1;
            nx[4]++;
            if (nx[4] > daysIn(mCnt[5], mCnt[6])) begin
              nx[4] = 1; nx[5]++;
              if (nx[5] > 12) begin
                nx[5] = 1; nx[6]++;
                if (nx[6] > 99) begin
                  nx[6] = 0;
                  nx[7] = (nx[7] >= 39) ? 0 : nx[7] + 1;
                end
              end
            end
          end
        end
      end
    end
    if (w) begin
      if (a == 5) begin mStop = d[7]; mE32 = d[6]; mBb = d[5]; end
      if (a < 8 && !mTe) begin mVis[a] = fromBcd(d & maskOf(a)); mDirty[a] = 1; end
      if (a == 15 && d[7] && !mTe) begin
        commit = 1;
        for (int i = 0; i < 8; i++) if (mDirty[i]) nx[i] = mVis[i];
        foreach (mDirty[i]) mDirty[i] = 0;
      end
    end
    follow = mTe || commit;
    if (w && a == 15) mTe = d[7];
    mCnt = nx;
    if (follow) mVis = nx;
  endtask

  task automatic step(input bit tk, input bit w, input int a, input int d);
    @(negedge clk);
    checks++;
    if (rdData !== 8'(expRead(int'(rdAddr)))) begin
      failures++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", curReq, rdAddr, rdData,
               expRead(int'(rdAddr)));
    end
    tickEn = tk; wrEn = w; wrAddr = 5'(a); wrData = 8'(d);
    rdAddr = rdAddr + 5'd1;
    @(posedge clk);
    modelClock(tk, w, a, d);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) step(tk, 0, 0, 0);
  endtask

  task automatic setAll(input int h, input int m, input int s, input int dw,
                        input int dt, input int mo, input int yr, input int ce);
    step(0, 1, 15, 'h00);
    step(0, 1, 0, toBcd(s));
    step(0, 1, 1, toBcd(m));
    step(0, 1, 2, toBcd(h));
    step(0, 1, 3, dw);
    step(0, 1, 4, toBcd(dt));
    step(0, 1, 5, toBcd(mo));
    step(0, 1, 6, toBcd(yr));
    step(0, 1, 7, toBcd(ce));
    step(0, 1, 15, 'h80);
  endtask

  initial begin
    modelReset();
    #9 rstN = 1'b1;

    curReq = "R10"; idle(34, 0);

    curReq = "R1"; setAll(23, 59, 50, 3, 15, 6, 20, 5); idle(40, 1);

    curReq = "R2";
    step(0, 1, 15, 'h00);
    step(0, 1, 0, 'hD5);
    step(0, 1, 2, 'hE3);
    step(0, 1, 3, 'hFE);
    step(0, 1, 10, 'hFF);
    step(0, 1, 20, 'hFF);
    step(0, 1, 15, 'hFF);
    idle(34, 0);

    curReq = "R4";
    step(0, 1, 1, 'h33);
    step(1, 1, 4, 'h22);
    idle(36, 1);

    curReq = "R3";
    step(1, 1, 15, 'h00);
    step(1, 1, 1, 'h12);
    idle(40, 1);

    curReq = "R5";
    step(1, 1, 15, 'h80);
    idle(70, 1);

    curReq = "R6";
    step(0, 1, 5, 'hE0);
    idle(34, 1);
    step(0, 1, 5, 'h00);
    idle(10, 1);

    curReq = "R7";
    setAll(23, 59, 58, 2, 28, 2, 23, 20); idle(36, 1);
    setAll(23, 59, 58, 2, 28, 2, 24, 20); idle(4, 1);
    setAll(23, 59, 59, 2, 29, 2, 24, 20); idle(4, 1);
    setAll(23, 59, 59, 2, 28, 2, 0, 20);  idle(4, 1);
    setAll(23, 59, 59, 2, 28, 2, 12, 20); idle(4, 1);
    setAll(23, 59, 59, 2, 28, 2, 10, 20); idle(4, 1);
    setAll(23, 59, 59, 2, 30, 4, 10, 20); idle(4, 1);
    setAll(23, 59, 59, 2, 30, 11, 10, 20); idle(4, 1);
    setAll(23, 59, 59, 2, 31, 1, 10, 20); idle(34, 1);

    curReq = "R8";
    setAll(23, 59, 59, 4, 31, 12, 99, 12); idle(34, 1);
    setAll(23, 59, 59, 4, 31, 12, 99, 39); idle(34, 1);

    curReq = "R9";
    setAll(23, 59, 59, 7, 10, 5, 30, 1); idle(34, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule